// File: doc/BRIEF.md
# Fairness-Bounded DRAM Command Scheduler

This block chooses, every clock cycle, at most one DRAM command to send from a shared transaction buffer that sits outside it. Each buffer slot presents a valid flag, a flat bank number, a row address, a fair-queuing start tag, and a ready flag. The ready flag already accounts for all device timing rules for that slot's next command. The scheduler keeps its own open-row record for every bank under an open-page policy. From that record it derives each slot's next command: a column access when the slot's row is already open in its bank, a precharge when a different row is open, and an activate when the bank is closed.

Selection favours slots that are ready, then column accesses over precharge and activate, then the smallest start tag, then the lowest slot index. Serving slots out of tag order lets row hits proceed. A bypass counter bounds how far this can go. Each issued command that does not belong to the oldest-tag transaction counts as a bypass. Once the programmed limit is reached, only the oldest-tag transaction may issue, and the scheduler waits for it to become ready.

The outputs are the chosen slot, its command, and its start tag. The buffer retires a slot after its column access has issued, and hands the reported tag back to the tag allocator.

Top module: `dram_fair_cmd_sched`

## Requirements
- R1: After reset every bank is closed and the bypass count is zero, so the first command offered to any slot is an activate.
- R2: Command codes on `issueCmd` are 0 none, 1 precharge, 2 activate, 3 column access. A slot whose bank holds its row gets 3, a slot whose bank holds another row gets 1, and a slot whose bank is closed gets 2.
- R3: A column access leaves the bank open on the same row, so a later slot for that bank and row is again offered a column access.
- R4: A precharge closes its bank. An activate opens its bank on the issuing slot's row.
- R5: Only a slot that is both valid and ready can issue. With no such slot allowed, `issueValid` is 0 and `issueCmd` is 0.
- R6: Outside forced mode, a ready column access wins over any ready precharge or activate.
- R7: Within the same command class, the smaller start tag wins. Equal tags go to the lower slot index.
- R8: The oldest-tag transaction is the valid slot with the smallest tag, lowest index on ties. With programmed limit T (0 treated as 1), at most T-1 consecutive issues may go to other slots. After that, only the oldest-tag slot may issue, and the scheduler stalls while it is not ready. T = 1 gives strict tag order.
- R9: An issue from the oldest-tag transaction clears the bypass count, so bypasses are allowed again afterwards.
- R10: Whenever a command issues, `issueTag` carries the start tag of the chosen slot. On a column access, this is the tag returned to the allocator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sptThreshold | input | THR_W | Bypass limit T |
| entValid | input | NUM_ENTRIES | Slot holds a transaction |
| entReady | input | NUM_ENTRIES | Slot's next command meets timing |
| entBank | input | NUM_ENTRIES*BANK_W | Flat bank number per slot (rank*banks per rank + bank) |
| entRow | input | NUM_ENTRIES*ROW_W | Row address per slot |
| entTag | input | NUM_ENTRIES*TAG_W | Start tag per slot |
| issueValid | output | 1 | A command issues this cycle |
| issueIdx | output | IDX_W | Chosen slot |
| issueCmd | output | 2 | Command code (see R2) |
| issueTag | output | TAG_W | Start tag of the chosen slot |

## Verification
A corrupted open-row record shows on the very next cycle in which a slot targets that bank: the slot is offered the wrong command code, for example a column access to a closed bank or a precharge where a hit should occur. A wrong bypass count shows as a stall that should not happen, or as an out-of-order issue once the limit has been reached. Either symptom is visible within one cycle of the first contested arbitration after the fault. The bench therefore exercises each command transition and each limit setting directly. It then compares every cycle of a long pseudo-random run against an arithmetic model.

// File: rtl/dsched_pkg.sv
`timescale 1ns/1ps
package dsched_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PRE  = 2'd1,
    CMD_ACT  = 2'd2,
    CMD_COL  = 2'd3
  } cmd_e;

  // Strobes from control to datapath for one issue decision
  typedef struct packed {
    logic issue;
    logic doPre;
    logic doAct;
    logic hitMin;
    logic bypass;
  } sched_strobe_t;

endpackage

// File: rtl/dsched_pick.sv
`timescale 1ns/1ps
// Lowest-key finder; ties resolve to the lowest index
module dsched_pick #(
  parameter int N     = 32,
  parameter int KEY_W = 9,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       req,
  input  logic [N*KEY_W-1:0] key,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);

  logic [KEY_W-1:0] bestKey;

  always_comb begin
    found   = 1'b0;
    idx     = '0;
    bestKey = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || (key[i*KEY_W +: KEY_W] < bestKey))) begin
        found   = 1'b1;
        idx     = IDX_W'(i);
        bestKey = key[i*KEY_W +: KEY_W];
      end
    end
  end

endmodule

// File: rtl/dsched_dp.sv
`timescale 1ns/1ps
// Datapath: per-bank open-row state, per-slot command decode, bypass count
module dsched_dp
  import dsched_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int NUM_BANKS   = 16,
  parameter int ROW_W       = 14,
  parameter int TAG_W       = 8,
  parameter int THR_W       = 6,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  sched_strobe_t                 strb,
  input  logic [IDX_W-1:0]              selIdx,
  input  logic [NUM_ENTRIES*BANK_W-1:0] entBank,
  input  logic [NUM_ENTRIES*ROW_W-1:0]  entRow,
  input  logic [NUM_ENTRIES*TAG_W-1:0]  entTag,
  output logic [NUM_ENTRIES*2-1:0]      entCmd,
  output logic [THR_W-1:0]              bypassCnt,
  output logic [TAG_W-1:0]              selTag
);

  logic [NUM_BANKS-1:0] bankOpen;
  logic [ROW_W-1:0]     bankRow [NUM_BANKS];
  logic [BANK_W-1:0]    selBank;
  logic [ROW_W-1:0]     selRow;

  assign selBank = entBank[selIdx*BANK_W +: BANK_W];
  assign selRow  = entRow[selIdx*ROW_W +: ROW_W];
  assign selTag  = entTag[selIdx*TAG_W +: TAG_W];

  // Open-row record, one register set per bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hitHere;
    assign hitHere = strb.issue && (selBank == BANK_W'(b));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankOpen[b] <= 1'b0;
        bankRow[b]  <= '0;
      end else if (hitHere && strb.doPre) begin
        bankOpen[b] <= 1'b0;
      end else if (hitHere && strb.doAct) begin
        bankOpen[b] <= 1'b1;
        bankRow[b]  <= selRow;
      end
    end
  end

  // Next-command decode per slot
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic [BANK_W-1:0] eBank;
    logic [ROW_W-1:0]  eRow;
    cmd_e              eCmd;
    assign eBank = entBank[e*BANK_W +: BANK_W];
    assign eRow  = entRow[e*ROW_W +: ROW_W];
    always_comb begin
      if (!bankOpen[eBank])             eCmd = CMD_ACT;
      else if (bankRow[eBank] == eRow)  eCmd = CMD_COL;
      else                              eCmd = CMD_PRE;
    end
    assign entCmd[e*2 +: 2] = eCmd;
  end

  // Consecutive-bypass counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 bypassCnt <= '0;
    else if (strb.hitMin)      bypassCnt <= '0;
    else if (strb.bypass && (bypassCnt != {THR_W{1'b1}}))
                               bypassCnt <= bypassCnt + 1'b1;
  end

endmodule

// File: rtl/dsched_ctrl.sv
`timescale 1ns/1ps
// Control: oldest-tag search, forced-mode decision, priority arbitration
module dsched_ctrl
  import dsched_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int TAG_W       = 8,
  parameter int THR_W       = 6,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int KEY_W = TAG_W + 1
) (
  input  logic [NUM_ENTRIES-1:0]       entValid,
  input  logic [NUM_ENTRIES-1:0]       entReady,
  input  logic [NUM_ENTRIES*TAG_W-1:0] entTag,
  input  logic [NUM_ENTRIES*2-1:0]     entCmd,
  input  logic [THR_W-1:0]             bypassCnt,
  input  logic [THR_W-1:0]             sptThreshold,
  output sched_strobe_t                strb,
  output logic [IDX_W-1:0]             selIdx,
  output cmd_e                         selCmd,
  output logic [IDX_W-1:0]             minIdx
);

  logic                     minFound;
  logic                     bestFound;
  logic                     forced;
  logic [THR_W:0]           effThr;
  logic [NUM_ENTRIES-1:0]   elig;
  logic [NUM_ENTRIES*KEY_W-1:0] prioKey;
  cmd_e                     chosenCmd;

  dsched_pick #(.N(NUM_ENTRIES), .KEY_W(TAG_W)) u_minPick (
    .req   (entValid),
    .key   (entTag),
    .found (minFound),
    .idx   (minIdx)
  );

  assign effThr = (sptThreshold == '0) ? (THR_W+1)'(1) : {1'b0, sptThreshold};
  assign forced = (({1'b0, bypassCnt} + 1'b1) >= effThr);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_key
    logic isCol;
    logic allowed;
    assign isCol   = (entCmd[e*2 +: 2] == CMD_COL);
    assign allowed = !forced || (minFound && (minIdx == IDX_W'(e)));
    assign elig[e] = entValid[e] && entReady[e] && allowed;
    assign prioKey[e*KEY_W +: KEY_W] = {!isCol, entTag[e*TAG_W +: TAG_W]};
  end

  dsched_pick #(.N(NUM_ENTRIES), .KEY_W(KEY_W)) u_bestPick (
    .req   (elig),
    .key   (prioKey),
    .found (bestFound),
    .idx   (selIdx)
  );

  assign chosenCmd = cmd_e'(entCmd[selIdx*2 +: 2]);
  assign selCmd    = bestFound ? chosenCmd : CMD_NONE;

  always_comb begin
    strb.issue  = bestFound;
    strb.doPre  = bestFound && (chosenCmd == CMD_PRE);
    strb.doAct  = bestFound && (chosenCmd == CMD_ACT);
    strb.hitMin = bestFound && (selIdx == minIdx);
    strb.bypass = bestFound && (selIdx != minIdx);
  end

endmodule

// File: rtl/dram_fair_cmd_sched.sv
`timescale 1ns/1ps
module dram_fair_cmd_sched
  import dsched_pkg::*;
#(
  parameter int NUM_ENTRIES    = 32,
  parameter int NUM_RANKS      = 2,
  parameter int BANKS_PER_RANK = 8,
  parameter int ROW_W          = 14,
  parameter int TAG_W          = 8,
  parameter int THR_W          = 6,
  localparam int NUM_BANKS = NUM_RANKS * BANKS_PER_RANK,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int IDX_W     = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [THR_W-1:0]              sptThreshold,
  input  logic [NUM_ENTRIES-1:0]        entValid,
  input  logic [NUM_ENTRIES-1:0]        entReady,
  input  logic [NUM_ENTRIES*BANK_W-1:0] entBank,
  input  logic [NUM_ENTRIES*ROW_W-1:0]  entRow,
  input  logic [NUM_ENTRIES*TAG_W-1:0]  entTag,
  output logic                          issueValid,
  output logic [IDX_W-1:0]              issueIdx,
  output logic [1:0]                    issueCmd,
  output logic [TAG_W-1:0]              issueTag
);

  sched_strobe_t            strb;
  logic [IDX_W-1:0]         selIdx;
  logic [IDX_W-1:0]         minIdx;
  cmd_e                     selCmd;
  logic [NUM_ENTRIES*2-1:0] entCmd;
  logic [THR_W-1:0]         bypassCnt;
  logic [TAG_W-1:0]         selTag;

  dsched_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W), .THR_W(THR_W)
  ) u_ctrl (
    .entValid     (entValid),
    .entReady     (entReady),
    .entTag       (entTag),
    .entCmd       (entCmd),
    .bypassCnt    (bypassCnt),
    .sptThreshold (sptThreshold),
    .strb         (strb),
    .selIdx       (selIdx),
    .selCmd       (selCmd),
    .minIdx       (minIdx)
  );

  dsched_dp #(
    .NUM_ENTRIES(NUM_ENTRIES), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W),
    .TAG_W(TAG_W), .THR_W(THR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .selIdx    (selIdx),
    .entBank   (entBank),
    .entRow    (entRow),
    .entTag    (entTag),
    .entCmd    (entCmd),
    .bypassCnt (bypassCnt),
    .selTag    (selTag)
  );

  assign issueValid = strb.issue;
  assign issueIdx   = selIdx;
  assign issueCmd   = selCmd;
  assign issueTag   = selTag;

endmodule

// File: rtl/dsched_chk.sv
`timescale 1ns/1ps
module dsched_chk #(
  parameter int NUM_ENTRIES = 32,
  parameter int TAG_W       = 8,
  parameter int THR_W       = 6,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [THR_W-1:0]             sptThreshold,
  input logic [NUM_ENTRIES-1:0]       entValid,
  input logic [NUM_ENTRIES-1:0]       entReady,
  input logic [NUM_ENTRIES*TAG_W-1:0] entTag,
  input logic [NUM_ENTRIES*2-1:0]     entCmd,
  input logic                         issueValid,
  input logic [IDX_W-1:0]             issueIdx,
  input logic [1:0]                   issueCmd,
  input logic [TAG_W-1:0]             issueTag,
  input logic [IDX_W-1:0]             minIdx
);

  logic [THR_W:0] chkCnt;
  logic [THR_W:0] effThr;
  logic           chkForced;
  logic           anyReadyCol;
  logic           anySmaller;

  assign effThr    = (sptThreshold == '0) ? (THR_W+1)'(1) : {1'b0, sptThreshold};
  assign chkForced = ((chkCnt + 1'b1) >= effThr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           chkCnt <= '0;
    else if (issueValid) chkCnt <= (issueIdx == minIdx) ? '0 : chkCnt + 1'b1;
  end

  always_comb begin
    anyReadyCol = 1'b0;
    anySmaller  = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (entValid[i] && entReady[i]) begin
        if (entCmd[i*2 +: 2] == 2'd3) anyReadyCol = 1'b1;
        if (((entCmd[i*2 +: 2] == 2'd3) == (issueCmd == 2'd3)) &&
            (entTag[i*TAG_W +: TAG_W] < issueTag))
          anySmaller = 1'b1;
      end
    end
  end

  assert_eligible_R5: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (entValid[issueIdx] && entReady[issueIdx]));

  assert_idle_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |-> (issueCmd == 2'd0));

  assert_col_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && (issueCmd != 2'd3) && !chkForced) |-> !anyReadyCol);

  assert_tag_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !chkForced) |-> !anySmaller);

  assert_bypass_cap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && (issueIdx != minIdx)) |-> ((chkCnt + 1'b1) < effThr));

  assert_tag_report_R10: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (issueTag == entTag[issueIdx*TAG_W +: TAG_W]));

endmodule

bind dram_fair_cmd_sched dsched_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W), .THR_W(THR_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .sptThreshold (sptThreshold),
  .entValid     (entValid),
  .entReady     (entReady),
  .entTag       (entTag),
  .entCmd       (entCmd),
  .issueValid   (issueValid),
  .issueIdx     (issueIdx),
  .issueCmd     (issueCmd),
  .issueTag     (issueTag),
  .minIdx       (minIdx)
);

// File: tb/dram_fair_cmd_sched_tb_top.sv
`timescale 1ns/1ps
module dram_fair_cmd_sched_tb_top;

  localparam int N     = 4;
  localparam int NR    = 2;
  localparam int BPR   = 2;
  localparam int NB    = NR * BPR;
  localparam int BW    = 2;
  localparam int ROWW  = 4;
  localparam int TAGW  = 6;
  localparam int THRW  = 3;
  localparam int IDXW  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [THRW-1:0] thr = 3'd7;

  logic            vV   [N];
  logic            vR   [N];
  logic [BW-1:0]   vBank[N];
  logic [ROWW-1:0] vRow [N];
  logic [TAGW-1:0] vTag [N];

  logic [N-1:0]      entValid, entReady;
  logic [N*BW-1:0]   entBank;
  logic [N*ROWW-1:0] entRow;
  logic [N*TAGW-1:0] entTag;

  logic            issueValid;
  logic [IDXW-1:0] issueIdx;
  logic [1:0]      issueCmd;
  logic [TAGW-1:0] issueTag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state for the sweep
  bit       mOpen[NB];
  int       mRow [NB];
  int       mCnt;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      entValid[i]               = vV[i];
      entReady[i]               = vR[i];
      entBank[i*BW +: BW]       = vBank[i];
      entRow[i*ROWW +: ROWW]    = vRow[i];
      entTag[i*TAGW +: TAGW]    = vTag[i];
    end
  end

  dram_fair_cmd_sched #(
    .NUM_ENTRIES(N), .NUM_RANKS(NR), .BANKS_PER_RANK(BPR),
    .ROW_W(ROWW), .TAG_W(TAGW), .THR_W(THRW)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sptThreshold(thr),
    .entValid(entValid), .entReady(entReady), .entBank(entBank),
    .entRow(entRow), .entTag(entTag),
    .issueValid(issueValid), .issueIdx(issueIdx),
    .issueCmd(issueCmd), .issueTag(issueTag)
  );

  task automatic clrAll();
    for (int i = 0; i < N; i++) begin
      vV[i] = 0; vR[i] = 0; vBank[i] = 0; vRow[i] = 0; vTag[i] = 0;
    end
  endtask

  task automatic setEnt(int i, bit r, int b, int row, int tag);
    vV[i] = 1; vR[i] = r; vBank[i] = BW'(b); vRow[i] = ROWW'(row); vTag[i] = TAGW'(tag);
  endtask

  // sample mid-low-phase, then move to the next falling edge
  task automatic expectOut(bit ev, int ei, int ec, int et, string lbl);
    bit ok;
    #5;
    checks++;
    if (ev) ok = issueValid && (int'(issueIdx) == ei) && (int'(issueCmd) == ec) && (int'(issueTag) == et);
    else    ok = !issueValid && (issueCmd == 2'd0);
    if (!ok) begin
      fails++;
      $display("FAIL %s: got valid=%0d idx=%0d cmd=%0d tag=%0d, expected valid=%0d idx=%0d cmd=%0d tag=%0d",
               lbl, issueValid, issueIdx, issueCmd, issueTag, ev, ei, ec, et);
    end
    @(negedge clk);
  endtask

  task automatic modelStep(output bit ev, output int ei, output int ec, output int et);
    int  cmd[N];
    int  minI, eff, bestRank, bestTag;
    bit  minF, forced;
    minF = 0; minI = 0;
    for (int i = 0; i < N; i++) begin
      int b;
      b = int'(vBank[i]);
      if (!mOpen[b])                  cmd[i] = 2;
      else if (mRow[b] == int'(vRow[i])) cmd[i] = 3;
      else                            cmd[i] = 1;
      if (vV[i] && (!minF || vTag[i] < vTag[minI])) begin minF = 1; minI = i; end
    end
    eff = (thr == 0) ? 1 : int'(thr);
    forced = (mCnt + 1) >= eff;
    ev = 0; ei = 0; ec = 0; et = 0; bestRank = 0; bestTag = 0;
    for (int i = 0; i < N; i++) begin
      int rank;
      if (vV[i] && vR[i] && (!forced || i == minI)) begin
        rank = (cmd[i] == 3) ? 0 : 1;
        if (!ev || rank < bestRank || (rank == bestRank && int'(vTag[i]) < bestTag)) begin
          ev = 1; ei = i; bestRank = rank; bestTag = int'(vTag[i]);
        end
      end
    end
    if (ev) begin
      ec = cmd[ei]; et = int'(vTag[ei]);
      if (ec == 1) mOpen[vBank[ei]] = 0;
      if (ec == 2) begin mOpen[vBank[ei]] = 1; mRow[vBank[ei]] = int'(vRow[ei]); end
      if (ei == minI) mCnt = 0; else mCnt++;
    end
  endtask

  initial begin
    bit [31:0] rs;
    clrAll();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 R5: idle after reset
    expectOut(0, 0, 0, 0, "R1 reset idle");
    setEnt(0, 1, 0, 3, 5);
    expectOut(1, 0, 2, 5, "R1 first command activate");
    expectOut(1, 0, 3, 5, "R2 hit gives column, R10 tag");
    setEnt(0, 1, 0, 3, 6);
    expectOut(1, 0, 3, 6, "R3 row stays open");
    setEnt(0, 1, 0, 7, 7);
    expectOut(1, 0, 1, 7, "R2 other row gives precharge");
    expectOut(1, 0, 2, 7, "R4 precharge closed bank");
    expectOut(1, 0, 3, 7, "R4 activate opened row");
    setEnt(0, 1, 1, 2, 1); setEnt(1, 1, 0, 7, 9);
    expectOut(1, 1, 3, 9, "R6 column over activate");
    clrAll(); setEnt(0, 0, 1, 2, 1);
    expectOut(0, 0, 0, 0, "R5 not ready idle");
    setEnt(0, 1, 1, 2, 4); setEnt(1, 1, 2, 0, 2);
    expectOut(1, 1, 2, 2, "R7 smaller tag");
    setEnt(0, 1, 1, 2, 3); setEnt(1, 1, 3, 5, 3);
    expectOut(1, 0, 2, 3, "R7 tie lower index");
    thr = 3'd1; setEnt(0, 0, 3, 1, 1); setEnt(1, 1, 0, 7, 8);
    expectOut(0, 0, 0, 0, "R8 limit one strict stall");
    thr = 3'd3;
    expectOut(1, 1, 3, 8, "R8 first bypass");
    expectOut(1, 1, 3, 8, "R8 second bypass");
    expectOut(0, 0, 0, 0, "R8 limit reached stall");
    vR[0] = 1;
    expectOut(1, 0, 2, 1, "R8 forced oldest issues");
    vR[0] = 0;
    expectOut(1, 1, 3, 8, "R9 count cleared bypass allowed");
    thr = 3'd0;
    expectOut(0, 0, 0, 0, "R8 zero limit acts as one");
    thr = 3'd7; vR[0] = 1;
    expectOut(1, 0, 3, 1, "R7 tag order among columns");

    // pseudo-random sweep against arithmetic model
    clrAll(); rstN = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1;
    for (int b = 0; b < NB; b++) begin mOpen[b] = 0; mRow[b] = 0; end
    mCnt = 0;
    rs = 32'h1234_5679;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      bit ev; int ei, ec, et;
      thr = THRW'((cyc / 200) % 8);
      for (int i = 0; i < N; i++) begin
        rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
        vV[i]    = rs[0] | rs[1];
        vR[i]    = rs[2] | rs[3];
        vBank[i] = rs[5:4];
        vRow[i]  = {3'b0, rs[6]};
        vTag[i]  = {3'b0, rs[9:7]};
      end
      #1;
      modelStep(ev, ei, ec, et);
      #4;
      checks++;
      if (ev ? !(issueValid && int'(issueIdx) == ei && int'(issueCmd) == ec && int'(issueTag) == et)
             : !(!issueValid && issueCmd == 2'd0)) begin
        fails++;
        $display("FAIL R2/R6/R7/R8/R9 sweep cycle %0d: got valid=%0d idx=%0d cmd=%0d tag=%0d, expected valid=%0d idx=%0d cmd=%0d tag=%0d",
                 cyc, issueValid, issueIdx, issueCmd, issueTag, ev, ei, ec, et);
      end
      @(negedge clk);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule